// File: doc/BRIEF.md
# Slice-Built Integer ALU with Signed Compare

This block is a purely combinational integer datapath unit. It is assembled from a chain of identical one-bit cells. Each cell holds a full adder, an AND gate, an OR gate and a four-way pick. The chain is parameterised in width, and the default width is 32. A three-bit code selects one of five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. The unit drives a result word, a flag that goes high when the result is all zeros, and a signed overflow flag.

The top bit of the code does two jobs. It inverts the B operand inside every cell, and it is the carry into the lowest cell. Subtraction therefore forms A plus the bitwise complement of B plus one. Set-on-less-than runs the same subtraction. It takes the sign of the difference, corrected by the overflow condition, and feeds it back into the lowest cell. That cell places it in result bit 0, and every other bit reads zero. A branch-on-equal decision is made by running a subtraction and looking at the zero flag.

Top module: `slice_alu`

## Requirements
- R1: Code 000 gives the bitwise AND of the two operands.
- R2: Code 001 gives the bitwise OR of the two operands.
- R3: Code 010 gives the sum of the operands modulo 2 to the power of the width.
- R4: Code 110 gives A minus B modulo 2 to the power of the width, formed as A plus the inverted B plus a carry-in of one.
- R5: Code 111 sets result bit 0 to 1 exactly when A is less than B as signed two's complement numbers, and this holds even when the difference overflows. All other result bits are 0.
- R6: The zero flag is 1 exactly when every result bit is 0, whatever the code.
- R7: For code 010, overflow is 1 exactly when both operands have the same sign and the result sign differs from it.
- R8: For code 110, overflow is 1 exactly when a non-negative A minus a negative B gives a negative result, or a negative A minus a non-negative B gives a non-negative result.
- R9: For codes 000, 001 and 111, overflow is 0.
- R10: Codes 011, 100 and 101 give a result of all zeros and an overflow of 0.
- R11: For code 110, the zero flag is 1 exactly when the two operands are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_a | input | WIDTH (32) | First operand, also the minuend |
| operand_b | input | WIDTH (32) | Second operand, also the subtrahend |
| op_code | input | 3 | Function select; bit 2 inverts B and supplies the carry into bit 0 |
| result | output | WIDTH (32) | Result word |
| is_zero | output | 1 | High when every result bit is zero |
| overflow | output | 1 | Signed overflow of an add or subtract |

## Verification
Two things can happen in the same evaluation: the subtraction overflows, and the set-on-less-than bit must still give the right signed answer. That bit is built from the same carries that produce the overflow. The bench provokes this case with operands at the extremes of the signed range, for example the most negative value against positive ones and the most positive value against negative ones. It does so at full width and across every operand pair of a four-bit instance. Each outcome is judged against a signed comparison that the bench computes in 64-bit arithmetic. Equality through the zero flag is judged in the same sweeps, and it depends on the same carry chain settling through all cells.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_LESS = 2'd3
    } pick_e;

    typedef struct packed {
        logic  invert_b;
        pick_e pick;
        logic  known;
        logic  arith;
    } ctrl_t;

    typedef struct packed {
        logic res;
        logic sum;
        logic cout;
    } slice_out_t;

    function automatic ctrl_t decode_op(input logic [2:0] code);
        ctrl_t c;
        c.invert_b = code[2];
        c.pick     = pick_e'(code[1:0]);
        c.known    = (code == OP_AND) || (code == OP_OR) || (code == OP_ADD) ||
                     (code == OP_SUB) || (code == OP_SLT);
        c.arith    = (code == OP_ADD) || (code == OP_SUB);
        return c;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       invert_b,
    input  logic       carry_in,
    input  logic       less_in,
    input  pick_e      pick,
    output slice_out_t o
);
    logic b_eff;

    always_comb begin
        b_eff  = b_bit ^ invert_b;
        o.sum  = a_bit ^ b_eff ^ carry_in;
        o.cout = (a_bit & b_eff) | (a_bit & carry_in) | (b_eff & carry_in);
        case (pick)
            PICK_AND:  o.res = a_bit & b_eff;
            PICK_OR:   o.res = a_bit | b_eff;
            PICK_SUM:  o.res = o.sum;
            default:   o.res = less_in;
        endcase
    end
endmodule

// File: rtl/alu_less_unit.sv
module alu_less_unit (
    input  logic carry_into_msb,
    input  logic carry_out_msb,
    input  logic sum_msb,
    input  logic arith,
    output logic set_bit,
    output logic overflow
);
    logic ovf_raw;

    always_comb begin
        ovf_raw  = carry_into_msb ^ carry_out_msb;
        set_bit  = sum_msb ^ ovf_raw;
        overflow = arith & ovf_raw;
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             all_clear
);
    assign all_clear = ~|value;
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] operand_a,
    input  logic [WIDTH-1:0] operand_b,
    input  logic [2:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             overflow
);
    localparam int MSB = WIDTH - 1;

    ctrl_t             ctl;
    logic [WIDTH:0]    carry;
    logic [WIDTH-1:0]  sums;
    logic [WIDTH-1:0]  raw_res;
    logic [WIDTH-1:0]  less_vec;
    logic              set_bit;
    slice_out_t        so [WIDTH];

    assign ctl      = decode_op(op_code);
    assign carry[0] = ctl.invert_b;
    assign less_vec = {{(WIDTH-1){1'b0}}, set_bit};

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_bit    (operand_a[i]),
            .b_bit    (operand_b[i]),
            .invert_b (ctl.invert_b),
            .carry_in (carry[i]),
            .less_in  (less_vec[i]),
            .pick     (ctl.pick),
            .o        (so[i])
        );
        assign raw_res[i]  = so[i].res;
        assign sums[i]     = so[i].sum;
        assign carry[i+1]  = so[i].cout;
    end

    alu_less_unit u_less (
        .carry_into_msb (carry[MSB]),
        .carry_out_msb  (carry[WIDTH]),
        .sum_msb        (sums[MSB]),
        .arith          (ctl.arith),
        .set_bit        (set_bit),
        .overflow       (overflow)
    );

    assign result = ctl.known ? raw_res : '0;

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value     (result),
        .all_clear (is_zero)
    );

    always_comb begin
        if (op_code == OP_AND) begin
            assert_and_R1: assert (result == (operand_a & operand_b));
        end
        if (op_code == OP_OR) begin
            assert_or_R2: assert (result == (operand_a | operand_b));
        end
        if (op_code == OP_ADD) begin
            assert_sum_R3: assert (result == WIDTH'(operand_a + operand_b));
            assert_add_ovf_R7: assert (overflow ==
                ((operand_a[MSB] == operand_b[MSB]) && (result[MSB] != operand_a[MSB])));
        end
        if (op_code == OP_SUB) begin
            assert_diff_R4: assert (result == WIDTH'(operand_a - operand_b));
            assert_eq_R11: assert (is_zero == (operand_a == operand_b));
            assert_sub_ovf_R8: assert (overflow ==
                ((operand_a[MSB] != operand_b[MSB]) && (result[MSB] != operand_a[MSB])));
        end
        if (op_code == OP_SLT) begin
            assert_slt_R5: assert (result ==
                {{(WIDTH-1){1'b0}}, ($signed(operand_a) < $signed(operand_b))});
        end
        if (op_code == OP_AND || op_code == OP_OR || op_code == OP_SLT) begin
            assert_no_overflow_R9: assert (!overflow);
        end
        if (op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101) begin
            assert_unused_R10: assert (result == '0 && !overflow && is_zero);
        end
    end
endmodule

// File: tb/test_slice_alu.sv
module test_slice_alu;
    localparam int WW = 32;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [WW-1:0] w_a, w_b, w_res;
    logic [2:0]    w_op;
    logic          w_zero, w_ovf;
    logic [NW-1:0] n_a, n_b, n_res;
    logic [2:0]    n_op;
    logic          n_zero, n_ovf;

    int checks = 0;
    int fails  = 0;

    slice_alu #(.WIDTH(WW)) i_slice_alu (
        .operand_a(w_a), .operand_b(w_b), .op_code(w_op),
        .result(w_res), .is_zero(w_zero), .overflow(w_ovf)
    );

    slice_alu #(.WIDTH(NW)) i_slice_alu_narrow (
        .operand_a(n_a), .operand_b(n_b), .op_code(n_op),
        .result(n_res), .is_zero(n_zero), .overflow(n_ovf)
    );

    task automatic compare(input string req, input string what,
                           input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [2:0] op);
        case (op)
            3'b010:                 return "R7";
            3'b110:                 return "R8";
            3'b000, 3'b001, 3'b111: return "R9";
            default:                return "R10";
        endcase
    endfunction

    // Arithmetic reference model for width w
    task automatic model(input int w, input logic [2:0] op, input longint ua, input longint ub,
                         output longint r, output longint z, output longint v);
        longint m, sa, sb, s, lo, hi;
        m  = (longint'(1) <<< w) - 1;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        sa = (ua > hi) ? ua - (longint'(1) <<< w) : ua;
        sb = (ub > hi) ? ub - (longint'(1) <<< w) : ub;
        v  = 0;
        case (op)
            3'b000: r = ua & ub;
            3'b001: r = ua | ub;
            3'b010: begin s = sa + sb; r = s & m; v = (s > hi || s < lo) ? 1 : 0; end
            3'b110: begin s = sa - sb; r = s & m; v = (s > hi || s < lo) ? 1 : 0; end
            3'b111: r = (sa < sb) ? 1 : 0;
            default: r = 0;
        endcase
        z = (r == 0) ? 1 : 0;
    endtask

    task automatic run_wide(input logic [2:0] op, input logic [WW-1:0] a, input logic [WW-1:0] b);
        longint r, z, v;
        @(posedge clk);
        w_op = op; w_a = a; w_b = b;
        @(negedge clk);
        model(WW, op, longint'(a), longint'(b), r, z, v);
        compare(res_tag(op), "wide result", longint'(w_res), r);
        compare(op == 3'b110 ? "R11" : "R6", "wide zero", longint'(w_zero), z);
        compare(ovf_tag(op), "wide overflow", longint'(w_ovf), v);
    endtask

    task automatic run_narrow(input logic [2:0] op, input logic [NW-1:0] a, input logic [NW-1:0] b);
        longint r, z, v;
        @(posedge clk);
        n_op = op; n_a = a; n_b = b;
        @(negedge clk);
        model(NW, op, longint'(a), longint'(b), r, z, v);
        compare(res_tag(op), "narrow result", longint'(n_res), r);
        compare(op == 3'b110 ? "R11" : "R6", "narrow zero", longint'(n_zero), z);
        compare(ovf_tag(op), "narrow overflow", longint'(n_ovf), v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [WW-1:0] da [9];
        logic [WW-1:0] db [9];
        int unsigned seed;
        w_a = '0; w_b = '0; w_op = 3'b000;
        n_a = '0; n_b = '0; n_op = 3'b000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle inputs: AND of zeros gives zero result, zero flag set (R1, R6)
        compare("R1", "idle result", longint'(w_res), 0);
        compare("R6", "idle zero", longint'(w_zero), 1);
        compare("R9", "idle overflow", longint'(w_ovf), 0);

        // signed-range corners, overflowing subtraction against SLT (R5, R8)
        da[0] = 32'h0000_0000; db[0] = 32'h0000_0000;
        da[1] = 32'h7FFF_FFFF; db[1] = 32'h0000_0001;
        da[2] = 32'h8000_0000; db[2] = 32'hFFFF_FFFF;
        da[3] = 32'h8000_0000; db[3] = 32'h0000_0001;
        da[4] = 32'h7FFF_FFFF; db[4] = 32'h8000_0000;
        da[5] = 32'hFFFF_FFFF; db[5] = 32'h0000_0001;
        da[6] = 32'h0000_0001; db[6] = 32'hFFFF_FFFF;
        da[7] = 32'h1234_5678; db[7] = 32'h1234_5678;
        da[8] = 32'hFFFF_FFFF; db[8] = 32'hFFFF_FFFF;
        for (int k = 0; k < 9; k++) begin
            for (int op = 0; op < 8; op++) begin
                run_wide(3'(op), da[k], db[k]);
            end
        end

        seed = 32'd17;
        void'($urandom(seed));
        for (int k = 0; k < 300; k++) begin
            logic [WW-1:0] ra, rb;
            ra = $urandom();
            rb = (k % 5 == 0) ? ra : $urandom();
            for (int op = 0; op < 8; op++) begin
                run_wide(3'(op), ra, rb);
            end
        end

        // exhaustive sweep of the narrow instance: every code, every pair
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < (1 << NW); a++) begin
                for (int b = 0; b < (1 << NW); b++) begin
                    run_narrow(3'(op), NW'(a), NW'(b));
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule